// File: doc/BRIEF.md
# Processor Status Flag Register Unit

This block keeps the eight-bit status word of a small 8-bit CPU. Each clock it looks at the class of the operation that just finished in the ALU, the ALU result and its carry, half-carry and signed-overflow indications. It then updates the matching condition flags. Dedicated strobes from the instruction decoder act on the control flags:

- interrupt enable on and off,
- direct page select and clear,
- clearing of overflow together with half carry,
- the software break marker.

An interrupt-service acknowledge clears the interrupt enable at once.

A full load path writes the whole word in one cycle, for example when status comes back from the stack. That load overrides every other update in the same cycle. The word is shown on one bus and as eight single-bit flags. The direct-page flag is also driven out as address bit 8, so direct addressing can be moved to the second 256-byte page. All updates are registered and appear one cycle after the inputs that cause them.

Top module: `psw_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears all eight status bits to 0. Interrupts start disabled and page 0 is selected.
- R2: The carry flag (bit 0) takes `alu_co` when `op_cls` is ARITH (1) or SHIFT (3). For any other class it keeps its value.
- R3: When `op_cls` is ARITH (1), MOVE (2) or SHIFT (3), the zero flag (bit 1) is set if `alu_res` is zero and cleared otherwise. In those same classes the negative flag (bit 7) takes `alu_res[7]`. With class NONE (0) or an unused code (5 to 7), both flags keep their values.
- R4: The half-carry flag (bit 3) takes `alu_hc` only for ARITH. The clear-overflow strobe `clrv_stb` is the only strobe that clears it. Other classes leave it unchanged.
- R5: The overflow flag (bit 6) takes `alu_ovf` for ARITH. `clrv_stb` clears it, and this wins over an ARITH update in the same cycle. No strobe sets it.
- R6: When `op_cls` is BIT (4), overflow takes `mem_opnd[6]` and negative takes `mem_opnd[7]`. Zero reflects `alu_res == 0`. Carry and half carry are unchanged.
- R7: The interrupt-enable flag (bit 2) is handled as follows:
  - `ei_stb` sets it.
  - `di_stb` clears it, and this wins over `ei_stb`.
  - `irq_ack` clears it, and this wins over both strobes.
- R8: The page flag (bit 5) is set by `setg_stb` and cleared by `clrg_stb`. The clear wins if both are active. `dp_hi` always equals this flag.
- R9: The break flag (bit 4) is set by `brk_stb` and stays set. Only reset or a full load changes it back.
- R10: When `ld_en` is 1, the next status word equals `ld_val`, whatever the other inputs are.
- R11: The word order from bit 7 to bit 0 is N, V, G, B, H, I, Z, C. Each single-flag output equals its bit of `psw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_res | input | 8 | ALU result |
| alu_co | input | 1 | Carry or borrow out |
| alu_hc | input | 1 | Bit-3 carry / no bit-4 borrow |
| alu_ovf | input | 1 | Signed overflow |
| op_cls | input | 3 | Operation class: 0 NONE, 1 ARITH, 2 MOVE, 3 SHIFT, 4 BIT |
| mem_opnd | input | 8 | Memory operand of the bit-test instruction |
| ei_stb | input | 1 | Enable interrupts |
| di_stb | input | 1 | Disable interrupts |
| setg_stb | input | 1 | Select direct page 1 |
| clrg_stb | input | 1 | Select direct page 0 |
| clrv_stb | input | 1 | Clear overflow and half carry |
| brk_stb | input | 1 | Software break taken |
| irq_ack | input | 1 | Interrupt serviced |
| ld_en | input | 1 | Full status load enable |
| ld_val | input | 8 | Full status load value |
| psw | output | 8 | Status word |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Overflow |
| flag_g | output | 1 | Direct page |
| flag_b | output | 1 | Break |
| flag_h | output | 1 | Half carry |
| flag_i | output | 1 | Interrupt enable |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry |
| dp_hi | output | 1 | Direct-page address bit 8 |

## Verification
The checker watches several rules on every cycle:
- reset clears the word;
- a full load lands intact;
- clear-overflow drops both V and H;
- an interrupt acknowledge drops I;
- the page strobes act on G;
- break stays set until a load;
- carry holds when no class touches it.

Other behaviour only shows in the bench scenarios. These include the value-dependent flag results: zero detection, the negative bit, the BIT instruction copying memory bits 7 and 6, and unused class codes acting as no-ops. The same holds for the priorities between simultaneous strobes and between a load and every other update.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int DW = 8;

    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_I = 2;
    localparam int POS_H = 3;
    localparam int POS_B = 4;
    localparam int POS_G = 5;
    localparam int POS_V = 6;
    localparam int POS_N = 7;

    localparam int SIGN_BIT = DW - 1;
    localparam int OVF_BIT  = DW - 2;

    typedef enum logic [2:0] {
        OPC_NONE  = 3'd0,
        OPC_ARITH = 3'd1,
        OPC_MOVE  = 3'd2,
        OPC_SHIFT = 3'd3,
        OPC_BIT   = 3'd4
    } op_cls_e;

    typedef struct packed {
        logic n;
        logic v;
        logic g;
        logic b;
        logic h;
        logic i;
        logic z;
        logic c;
    } psw_t;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic h;
        logic v;
    } cond_t;

    typedef struct packed {
        logic i;
        logic g;
        logic b;
    } ctrl_t;

    function automatic logic is_zero(input logic [DW-1:0] val);
        return (val == '0);
    endfunction

endpackage

// File: rtl/psw_cond_flags.sv
module psw_cond_flags
    import psw_pkg::*;
(
    input  logic [2:0]    op_cls,
    input  logic [DW-1:0] alu_res,
    input  logic          alu_co,
    input  logic          alu_hc,
    input  logic          alu_ovf,
    input  logic [DW-1:0] mem_opnd,
    input  logic          clrv_stb,
    input  cond_t         cur,
    output cond_t         nxt
);

    always_comb begin
        nxt = cur;
        case (op_cls)
            OPC_ARITH: begin
                nxt.c = alu_co;
                nxt.z = is_zero(alu_res);
                nxt.n = alu_res[SIGN_BIT];
                nxt.h = alu_hc;
                nxt.v = alu_ovf;
            end
            OPC_MOVE: begin
                nxt.z = is_zero(alu_res);
                nxt.n = alu_res[SIGN_BIT];
            end
            OPC_SHIFT: begin
                nxt.c = alu_co;
                nxt.z = is_zero(alu_res);
                nxt.n = alu_res[SIGN_BIT];
            end
            OPC_BIT: begin
                nxt.z = is_zero(alu_res);
                nxt.n = mem_opnd[SIGN_BIT];
                nxt.v = mem_opnd[OVF_BIT];
            end
            default: ;
        endcase
        if (clrv_stb) begin
            nxt.v = 1'b0;
            nxt.h = 1'b0;
        end
    end

endmodule

// File: rtl/psw_ctrl_flags.sv
module psw_ctrl_flags
    import psw_pkg::*;
(
    input  logic  ei_stb,
    input  logic  di_stb,
    input  logic  irq_ack,
    input  logic  setg_stb,
    input  logic  clrg_stb,
    input  logic  brk_stb,
    input  ctrl_t cur,
    output ctrl_t nxt
);

    always_comb begin
        nxt = cur;
        if (irq_ack || di_stb) nxt.i = 1'b0;
        else if (ei_stb)       nxt.i = 1'b1;
        if (clrg_stb)          nxt.g = 1'b0;
        else if (setg_stb)     nxt.g = 1'b1;
        if (brk_stb)           nxt.b = 1'b1;
    end

endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
    import psw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] alu_res,
    input  logic          alu_co,
    input  logic          alu_hc,
    input  logic          alu_ovf,
    input  logic [2:0]    op_cls,
    input  logic [DW-1:0] mem_opnd,
    input  logic          ei_stb,
    input  logic          di_stb,
    input  logic          setg_stb,
    input  logic          clrg_stb,
    input  logic          clrv_stb,
    input  logic          brk_stb,
    input  logic          irq_ack,
    input  logic          ld_en,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] psw,
    output logic          flag_n,
    output logic          flag_v,
    output logic          flag_g,
    output logic          flag_b,
    output logic          flag_h,
    output logic          flag_i,
    output logic          flag_z,
    output logic          flag_c,
    output logic          dp_hi
);

    psw_t  state_q;
    psw_t  state_d;
    cond_t cond_cur;
    cond_t cond_nxt;
    ctrl_t ctrl_cur;
    ctrl_t ctrl_nxt;

    assign cond_cur = '{c: state_q.c, z: state_q.z, n: state_q.n,
                        h: state_q.h, v: state_q.v};
    assign ctrl_cur = '{i: state_q.i, g: state_q.g, b: state_q.b};

    psw_cond_flags u_cond (
        .op_cls   (op_cls),
        .alu_res  (alu_res),
        .alu_co   (alu_co),
        .alu_hc   (alu_hc),
        .alu_ovf  (alu_ovf),
        .mem_opnd (mem_opnd),
        .clrv_stb (clrv_stb),
        .cur      (cond_cur),
        .nxt      (cond_nxt)
    );

    psw_ctrl_flags u_ctrl (
        .ei_stb   (ei_stb),
        .di_stb   (di_stb),
        .irq_ack  (irq_ack),
        .setg_stb (setg_stb),
        .clrg_stb (clrg_stb),
        .brk_stb  (brk_stb),
        .cur      (ctrl_cur),
        .nxt      (ctrl_nxt)
    );

    always_comb begin
        if (ld_en) begin
            state_d = psw_t'(ld_val);
        end else begin
            state_d.n = cond_nxt.n;
            state_d.v = cond_nxt.v;
            state_d.g = ctrl_nxt.g;
            state_d.b = ctrl_nxt.b;
            state_d.h = cond_nxt.h;
            state_d.i = ctrl_nxt.i;
            state_d.z = cond_nxt.z;
            state_d.c = cond_nxt.c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign psw    = state_q;
    assign flag_n = state_q.n;
    assign flag_v = state_q.v;
    assign flag_g = state_q.g;
    assign flag_b = state_q.b;
    assign flag_h = state_q.h;
    assign flag_i = state_q.i;
    assign flag_z = state_q.z;
    assign flag_c = state_q.c;
    assign dp_hi  = state_q.g;

endmodule

// File: rtl/psw_flag_unit_chk.sv
module psw_flag_unit_chk
    import psw_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [2:0]    op_cls,
    input logic          setg_stb,
    input logic          clrg_stb,
    input logic          clrv_stb,
    input logic          irq_ack,
    input logic          ld_en,
    input logic [DW-1:0] ld_val,
    input logic [DW-1:0] psw,
    input logic          dp_hi
);

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> psw == '0);

    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> psw == $past(ld_val));

    a_r5_clrv_drops_v: assert property (@(posedge clk) disable iff (rst)
        (clrv_stb && !ld_en) |=> !psw[POS_V]);

    a_r4_clrv_drops_h: assert property (@(posedge clk) disable iff (rst)
        (clrv_stb && !ld_en) |=> !psw[POS_H]);

    a_r7_ack_masks: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !ld_en) |=> !psw[POS_I]);

    a_r8_page_set: assert property (@(posedge clk) disable iff (rst)
        (setg_stb && !clrg_stb && !ld_en) |=> dp_hi);

    a_r8_page_clr: assert property (@(posedge clk) disable iff (rst)
        (clrg_stb && !ld_en) |=> !dp_hi);

    a_r9_brk_sticky: assert property (@(posedge clk) disable iff (rst)
        (psw[POS_B] && !ld_en) |=> psw[POS_B]);

    a_r2_carry_hold: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && op_cls != OPC_ARITH && op_cls != OPC_SHIFT)
        |=> $stable(psw[POS_C]));

endmodule

bind psw_flag_unit psw_flag_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_cls   (op_cls),
    .setg_stb (setg_stb),
    .clrg_stb (clrg_stb),
    .clrv_stb (clrv_stb),
    .irq_ack  (irq_ack),
    .ld_en    (ld_en),
    .ld_val   (ld_val),
    .psw      (psw),
    .dp_hi    (dp_hi)
);

// File: tb/psw_flag_unit_tb.sv
module psw_flag_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] alu_res = '0;
    logic       alu_co = 1'b0, alu_hc = 1'b0, alu_ovf = 1'b0;
    logic [2:0] op_cls = '0;
    logic [7:0] mem_opnd = '0;
    logic       ei_stb = 0, di_stb = 0, setg_stb = 0, clrg_stb = 0;
    logic       clrv_stb = 0, brk_stb = 0, irq_ack = 0, ld_en = 0;
    logic [7:0] ld_val = '0;
    logic [7:0] psw;
    logic       flag_n, flag_v, flag_g, flag_b, flag_h, flag_i, flag_z, flag_c, dp_hi;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = '0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    psw_flag_unit u_dut (
        .clk(clk), .rst(rst), .alu_res(alu_res), .alu_co(alu_co),
        .alu_hc(alu_hc), .alu_ovf(alu_ovf), .op_cls(op_cls),
        .mem_opnd(mem_opnd), .ei_stb(ei_stb), .di_stb(di_stb),
        .setg_stb(setg_stb), .clrg_stb(clrg_stb), .clrv_stb(clrv_stb),
        .brk_stb(brk_stb), .irq_ack(irq_ack), .ld_en(ld_en),
        .ld_val(ld_val), .psw(psw), .flag_n(flag_n), .flag_v(flag_v),
        .flag_g(flag_g), .flag_b(flag_b), .flag_h(flag_h),
        .flag_i(flag_i), .flag_z(flag_z), .flag_c(flag_c), .dp_hi(dp_hi)
    );

    // bit order N V G B H I Z C
    function automatic logic [7:0] predict(input logic [7:0] p);
        logic [7:0] q = p;
        if (ld_en) return ld_val;
        if (op_cls == 3'd1 || op_cls == 3'd3) q[0] = alu_co;
        if (op_cls >= 3'd1 && op_cls <= 3'd4) q[1] = (alu_res == 8'h00);
        if (op_cls >= 3'd1 && op_cls <= 3'd3) q[7] = alu_res[7];
        if (op_cls == 3'd1) begin q[3] = alu_hc; q[6] = alu_ovf; end
        if (op_cls == 3'd4) begin q[7] = mem_opnd[7]; q[6] = mem_opnd[6]; end
        if (clrv_stb) begin q[6] = 1'b0; q[3] = 1'b0; end
        if (irq_ack || di_stb) q[2] = 1'b0; else if (ei_stb) q[2] = 1'b1;
        if (clrg_stb) q[5] = 1'b0; else if (setg_stb) q[5] = 1'b1;
        if (brk_stb) q[4] = 1'b1;
        return q;
    endfunction

    task automatic idle();
        alu_res = '0; alu_co = 0; alu_hc = 0; alu_ovf = 0; op_cls = '0;
        mem_opnd = '0; ei_stb = 0; di_stb = 0; setg_stb = 0; clrg_stb = 0;
        clrv_stb = 0; brk_stb = 0; irq_ack = 0; ld_en = 0; ld_val = '0;
    endtask

    // inputs already set by caller at a negedge; push expectation and advance
    task automatic drive(input string tag);
        item_t it;
        model  = predict(model);
        it.exp = model;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        idle();
    endtask

    task automatic alu(input logic [2:0] cls, input logic [7:0] res,
                       input logic co, input logic hc, input logic ov,
                       input string tag);
        op_cls = cls; alu_res = res; alu_co = co; alu_hc = hc; alu_ovf = ov;
        drive(tag);
    endtask

    // monitor: result of the edge appears right after it
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            logic [7:0] fl;
            it = sb.pop_front();
            fl = {flag_n, flag_v, flag_g, flag_b, flag_h, flag_i, flag_z, flag_c};
            checks++;
            if (psw !== it.exp) begin
                errors++;
                $display("FAIL %s psw actual %h expected %h", it.tag, psw, it.exp);
            end
            checks++;
            if (fl !== it.exp || dp_hi !== it.exp[5]) begin
                errors++;
                $display("FAIL R11 flags actual %h/%b expected %h/%b",
                         fl, dp_hi, it.exp, it.exp[5]);
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (psw !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset actual %h expected 00", psw);
        end
        rst = 1'b0;
        model = 8'h00;

        // R2 R3 R4 R5 arithmetic
        alu(3'd1, 8'h00, 1, 1, 1, "R2 R3 R4 R5 arith zero");
        alu(3'd1, 8'h85, 0, 0, 0, "R3 arith negative");
        alu(3'd1, 8'h7F, 1, 1, 0, "R2 arith carry");
        // R2 R4 move keeps C,H
        alu(3'd2, 8'h00, 0, 0, 0, "R2 R4 move keeps C H");
        alu(3'd2, 8'hF0, 1, 0, 1, "R3 move negative");
        // R2 shift
        alu(3'd3, 8'h01, 0, 1, 1, "R2 shift carry clr");
        alu(3'd3, 8'h80, 1, 0, 0, "R2 shift carry set");
        // unused class codes are no-ops
        alu(3'd0, 8'h00, 0, 0, 0, "R3 class none");
        alu(3'd6, 8'h00, 0, 1, 1, "R3 unused class");
        // R5 set V via arith then clrv
        alu(3'd1, 8'h80, 0, 1, 1, "R5 arith overflow");
        clrv_stb = 1; drive("R4 R5 clrv");
        op_cls = 3'd1; alu_res = 8'h10; alu_hc = 1; alu_ovf = 1; clrv_stb = 1;
        drive("R5 clrv beats arith");
        // R6 BIT
        op_cls = 3'd4; mem_opnd = 8'h40; alu_res = 8'h00; alu_co = 0;
        drive("R6 bit V from mem");
        op_cls = 3'd4; mem_opnd = 8'h80; alu_res = 8'h01; alu_co = 1; alu_hc = 1;
        drive("R6 bit N from mem");
        // R7
        ei_stb = 1; drive("R7 ei");
        di_stb = 1; ei_stb = 1; drive("R7 di beats ei");
        ei_stb = 1; drive("R7 ei again");
        irq_ack = 1; ei_stb = 1; drive("R7 ack beats ei");
        // R8
        setg_stb = 1; drive("R8 setg");
        alu(3'd2, 8'h33, 0, 0, 0, "R8 page holds");
        setg_stb = 1; clrg_stb = 1; drive("R8 clrg wins");
        // R9
        brk_stb = 1; drive("R9 brk");
        alu(3'd1, 8'h00, 0, 0, 0, "R9 brk sticky");
        clrv_stb = 1; di_stb = 1; clrg_stb = 1; drive("R9 brk kept by strobes");
        // R10
        ld_en = 1; ld_val = 8'hA5; op_cls = 3'd1; alu_res = 8'h00;
        alu_co = 0; brk_stb = 1; ei_stb = 1; drive("R10 load A5");
        ld_en = 1; ld_val = 8'h5A; clrv_stb = 1; irq_ack = 1; setg_stb = 1;
        drive("R10 load 5A");
        ld_en = 1; ld_val = 8'h00; drive("R10 load clears B");
        // R11 each bit alone via load
        for (int k = 0; k < 8; k++) begin
            ld_en = 1; ld_val = 8'(1 << k); drive("R11 single bit");
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = 8'h00;
        repeat (2) @(negedge clk);
        checks++;
        if (psw !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset mid-run actual %h expected 00", psw);
        end
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule